// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits beside an SDRAM command scheduler and follows the stream of decoded commands sent to a four-bank device. For every bank it keeps a small state machine and a cycle counter. From these it tells the scheduler, each clock, which command classes may legally be issued to which bank: row activate, column read or write, precharge, and refresh. It also reports which banks hold an open row, requests a precharge when a row has been open for nearly its maximum time, and emits a one-cycle violation pulse with a code and a bank number whenever an illegal command goes by.

Every timing limit is a picosecond parameter. It is converted to whole clocks by dividing by the clock period and rounding up, with a floor of one clock. Each bank machine has four states. `B_CLOSED` goes to `B_OPENING` on ACTIVE. `B_OPENING` goes to `B_OPEN` once the activate-to-column delay has elapsed, and to `B_PRECHG` on PRECHARGE. `B_OPEN` goes to `B_PRECHG` on PRECHARGE. `B_PRECHG` goes to `B_OPENING` on ACTIVE, or to `B_CLOSED` once the precharge recovery has elapsed. Two shared counters track the time since the last ACTIVE to any bank and the time since the last REFRESH.

The block makes no command decisions. A command that breaks a timing rule still updates the bank state. A command that breaks a state rule does not.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, every bank is closed, `rdy_act` and `rdy_pre` are all ones, `rdy_rw`, `bank_open` and `force_pre` are all zeros, `rdy_ref` is 1 and no violation is flagged.
- R2: Commands are taken on a clock edge where `cmd_vld` is 1. The `cmd_op` encodings are 0 ACTIVE, 1 READ, 2 WRITE, 3 PRECHARGE (one bank), 4 PRECHARGE ALL and 5 REFRESH. Codes 6 and 7 have no effect and raise no violation.
- R3: After an ACTIVE, `rdy_rw` for that bank stays 0 until the activate-to-column delay (in clocks) has passed. A READ or WRITE issued before then gives violation code 3.
- R4: Once a bank is open and past its activate-to-column delay, READ and WRITE commands to it are legal on consecutive clocks.
- R5: PRECHARGE of an open bank is legal only once both of these hold: the row has been open for the minimum row time, and the write-recovery time has passed since the last WRITE. Otherwise the PRECHARGE gives violation code 4. PRECHARGE of a closed bank is always legal.
- R6: After a PRECHARGE, the bank's `rdy_act` stays 0 for the precharge recovery time. An ACTIVE issued before then gives violation code 5, and the bank opens anyway.
- R7: After an ACTIVE to any bank, `rdy_act` is 0 for every bank until the activate-to-activate spacing has passed. An ACTIVE issued before then gives code 5.
- R8: `rdy_ref` is 1 only when every bank is closed and recovered. A REFRESH issued otherwise gives code 6. After a REFRESH, `rdy_ref` and every `rdy_act` stay 0 for the refresh cycle time.
- R9: A READ or WRITE to a closed bank gives code 1. An ACTIVE to an open bank gives code 2. Neither changes the bank state.
- R10: A violation appears as `viol_vld`=1 for exactly the one cycle after the offending clock edge, with `viol_code` nonzero and `viol_bank` set to the bank concerned.
- R11: PRECHARGE ALL closes every bank. If any open bank is not ready for precharge, it gives code 4 with the lowest such bank.
- R12: `force_pre` for a bank rises once its row has been open for (maximum row time − `WARN_CLK`) clocks. If the row stays open for the full maximum row time with no precharge, one code-7 pulse is raised for that bank.
- R13: Each clock count equals the picosecond limit divided by `CLK_PS`, rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command type (see R2) |
| cmd_bank | input | $clog2(NB) | Target bank |
| rdy_act | output | NB | ACTIVE to this bank is legal now |
| rdy_rw | output | NB | READ or WRITE to this bank is legal now |
| rdy_pre | output | NB | PRECHARGE of this bank is legal now |
| rdy_ref | output | 1 | REFRESH is legal now |
| bank_open | output | NB | Bank holds an open row |
| force_pre | output | NB | Row close to its maximum open time |
| viol_vld | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Violation code (1..7) |
| viol_bank | output | $clog2(NB) | Bank the violation refers to |

## Verification
Each timing limit is probed with a command issued one clock before the limit expires and again exactly at the limit. This separates an off-by-one counter from a correct one and confirms that the rounded-up clock counts are in force. State-rule errors (column access to a closed bank, activating an open bank) are contrasted with timing-rule errors on the same command to show that the two kinds are coded apart and update the state differently. PRECHARGE ALL is tried with two banks of different row ages, so that the lowest offending bank is reported. A row is left open past its limit to show that the warning comes first and that the violation pulses only once.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    localparam logic [2:0] OP_ACT  = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_WR   = 3'd2;
    localparam logic [2:0] OP_PRE  = 3'd3;
    localparam logic [2:0] OP_PREA = 3'd4;
    localparam logic [2:0] OP_REF  = 3'd5;

    localparam logic [2:0] V_NONE      = 3'd0;
    localparam logic [2:0] V_RW_CLOSED = 3'd1;
    localparam logic [2:0] V_ACT_OPEN  = 3'd2;
    localparam logic [2:0] V_EARLY_RW  = 3'd3;
    localparam logic [2:0] V_EARLY_PRE = 3'd4;
    localparam logic [2:0] V_EARLY_ACT = 3'd5;
    localparam logic [2:0] V_REF_BUSY  = 3'd6;
    localparam logic [2:0] V_ROW_LONG  = 3'd7;

    typedef enum logic [1:0] {
        B_CLOSED  = 2'd0,
        B_OPENING = 2'd1,
        B_OPEN    = 2'd2,
        B_PRECHG  = 2'd3
    } bank_st_e;

    // limit in ps -> whole clocks, rounded up, at least one
    function automatic int ps_to_clk(input int lim_ps, input int per_ps);
        int c;
        c = (lim_ps + per_ps - 1) / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sbt_since.sv
module sbt_since #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = ($clog2(LIMIT + 1) < 1) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(LIMIT);
        else if (start)
            cnt <= W'(1);
        else if (cnt < W'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= W'(LIMIT));

endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int RCD     = 2,
    parameter int RAS_MIN = 5,
    parameter int RAS_MAX = 10000,
    parameter int RP      = 2,
    parameter int WR      = 1,
    parameter int WARN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_wr,
    input  logic do_pre,
    output logic is_open,
    output logic rw_ok,
    output logic pre_ok,
    output logic act_ok,
    output logic warn,
    output logic expire
);
    localparam int AW      = $clog2(RAS_MAX + 2);
    localparam int WARN_AT = (WARN >= RAS_MAX) ? 1 : RAS_MAX - WARN;

    bank_st_e       st, st_nxt;
    logic [AW-1:0]  age;
    logic           wr_done;
    logic           open_c;

    assign open_c = (st == B_OPENING) || (st == B_OPEN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= B_CLOSED;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            B_CLOSED:  if (do_act) st_nxt = B_OPENING;
            B_OPENING: begin
                if (do_pre)                  st_nxt = B_PRECHG;
                else if (age >= AW'(RCD))    st_nxt = B_OPEN;
            end
            B_OPEN:    if (do_pre) st_nxt = B_PRECHG;
            B_PRECHG: begin
                if (do_act)                  st_nxt = B_OPENING;
                else if (age >= AW'(RP))     st_nxt = B_CLOSED;
            end
        endcase
    end

    // age of the current row or of the current precharge
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= AW'(RAS_MAX + 1);
        else if (do_act && !open_c)
            age <= AW'(1);
        else if (do_pre && open_c)
            age <= AW'(1);
        else if (age <= AW'(RAS_MAX))
            age <= age + 1'b1;
    end

    sbt_since #(.LIMIT(WR)) u_wr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(do_wr && open_c),
        .done (wr_done)
    );

    // outputs
    always_comb begin
        is_open = open_c;
        rw_ok   = open_c && (age >= AW'(RCD));
        pre_ok  = !open_c || ((age >= AW'(RAS_MIN)) && wr_done);
        act_ok  = (st == B_CLOSED) || ((st == B_PRECHG) && (age >= AW'(RP)));
        warn    = open_c && (age >= AW'(WARN_AT));
        expire  = open_c && (age == AW'(RAS_MAX)) && !do_pre;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NB           = 4,
    parameter int CLK_PS       = 10000,
    parameter int T_RCD_PS     = 20000,
    parameter int T_RAS_MIN_PS = 45000,
    parameter int T_RAS_MAX_PS = 100000000,
    parameter int T_RP_PS      = 20000,
    parameter int T_RRD_PS     = 15000,
    parameter int T_WR_PS      = 10000,
    parameter int T_RC_PS      = 65000,
    parameter int WARN_CLK     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_vld,
    input  logic [2:0]            cmd_op,
    input  logic [$clog2(NB)-1:0] cmd_bank,
    output logic [NB-1:0]         rdy_act,
    output logic [NB-1:0]         rdy_rw,
    output logic [NB-1:0]         rdy_pre,
    output logic                  rdy_ref,
    output logic [NB-1:0]         bank_open,
    output logic [NB-1:0]         force_pre,
    output logic                  viol_vld,
    output logic [2:0]            viol_code,
    output logic [$clog2(NB)-1:0] viol_bank
);
    localparam int BW        = $clog2(NB);
    localparam int RCD_C     = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int RAS_MIN_C = ps_to_clk(T_RAS_MIN_PS, CLK_PS);
    localparam int RAS_MAX_C = ps_to_clk(T_RAS_MAX_PS, CLK_PS);
    localparam int RP_C      = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int RRD_C     = ps_to_clk(T_RRD_PS, CLK_PS);
    localparam int WR_C      = ps_to_clk(T_WR_PS, CLK_PS);
    localparam int RC_C      = ps_to_clk(T_RC_PS, CLK_PS);

    logic [NB-1:0] do_act, do_wr, do_pre;
    logic [NB-1:0] act_ok, expire;
    logic          act_gap, ref_gap;
    logic [2:0]    v_code;
    logic [BW-1:0] v_bank;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic sel;
        assign sel       = cmd_vld && (cmd_bank == BW'(i));
        assign do_act[i] = sel && (cmd_op == OP_ACT) && !bank_open[i];
        assign do_wr[i]  = sel && (cmd_op == OP_WR);
        assign do_pre[i] = (sel && (cmd_op == OP_PRE)) ||
                           (cmd_vld && (cmd_op == OP_PREA));

        sbt_bank #(
            .RCD(RCD_C), .RAS_MIN(RAS_MIN_C), .RAS_MAX(RAS_MAX_C),
            .RP(RP_C), .WR(WR_C), .WARN(WARN_CLK)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_act (do_act[i]),
            .do_wr  (do_wr[i]),
            .do_pre (do_pre[i]),
            .is_open(bank_open[i]),
            .rw_ok  (rdy_rw[i]),
            .pre_ok (rdy_pre[i]),
            .act_ok (act_ok[i]),
            .warn   (force_pre[i]),
            .expire (expire[i])
        );

        assign rdy_act[i] = act_ok[i] && act_gap && ref_gap;
    end

    sbt_since #(.LIMIT(RRD_C)) u_rrd (
        .clk(clk), .rst_n(rst_n), .start(|do_act), .done(act_gap)
    );

    sbt_since #(.LIMIT(RC_C)) u_rc (
        .clk(clk), .rst_n(rst_n),
        .start(cmd_vld && (cmd_op == OP_REF)), .done(ref_gap)
    );

    assign rdy_ref = (&act_ok) && ref_gap;

    // rule check on the command presented this cycle
    always_comb begin
        v_code = V_NONE;
        v_bank = '0;
        if (cmd_vld) begin
            case (cmd_op)
                OP_ACT: begin
                    if (bank_open[cmd_bank])     v_code = V_ACT_OPEN;
                    else if (!rdy_act[cmd_bank]) v_code = V_EARLY_ACT;
                    v_bank = cmd_bank;
                end
                OP_RD, OP_WR: begin
                    if (!bank_open[cmd_bank])    v_code = V_RW_CLOSED;
                    else if (!rdy_rw[cmd_bank])  v_code = V_EARLY_RW;
                    v_bank = cmd_bank;
                end
                OP_PRE: begin
                    if (!rdy_pre[cmd_bank])      v_code = V_EARLY_PRE;
                    v_bank = cmd_bank;
                end
                OP_PREA: begin
                    for (int i = NB - 1; i >= 0; i--) begin
                        if (!rdy_pre[i]) begin
                            v_code = V_EARLY_PRE;
                            v_bank = BW'(i);
                        end
                    end
                end
                OP_REF: if (!rdy_ref) v_code = V_REF_BUSY;
                default: ;
            endcase
        end
        if (v_code == V_NONE) begin
            for (int i = NB - 1; i >= 0; i--) begin
                if (expire[i]) begin
                    v_code = V_ROW_LONG;
                    v_bank = BW'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_vld  <= 1'b0;
            viol_code <= V_NONE;
            viol_bank <= '0;
        end else begin
            viol_vld  <= (v_code != V_NONE);
            viol_code <= v_code;
            viol_bank <= v_bank;
        end
    end

endmodule

// File: rtl/sbt_checks.sv
module sbt_checks
    import sbt_pkg::*;
#(
    parameter int NB    = 4,
    parameter int RCD_C = 2,
    parameter int RRD_C = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_vld,
    input logic [2:0]            cmd_op,
    input logic [$clog2(NB)-1:0] cmd_bank,
    input logic [NB-1:0]         rdy_act,
    input logic [NB-1:0]         rdy_rw,
    input logic                  rdy_ref,
    input logic [NB-1:0]         bank_open,
    input logic [NB-1:0]         force_pre,
    input logic                  viol_vld,
    input logic [2:0]            viol_code
);
    localparam int BW = $clog2(NB);

    for (genvar i = 0; i < NB; i++) begin : g_chk
        AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_vld && cmd_op == OP_ACT && cmd_bank == BW'(i) && !bank_open[i]
            |=> bank_open[i]); // R2

        AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_vld && (cmd_op == OP_PREA || (cmd_op == OP_PRE && cmd_bank == BW'(i)))
            |=> !bank_open[i]); // R11

        AST_RW_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_vld && (cmd_op == OP_RD || cmd_op == OP_WR) && cmd_bank == BW'(i) && !bank_open[i]
            |=> viol_vld && viol_code == V_RW_CLOSED && !bank_open[i]); // R9

        AST_FORCE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            force_pre[i] |-> bank_open[i]); // R12

        if (RCD_C > 1) begin : g_rcd
            AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_vld && cmd_op == OP_ACT && cmd_bank == BW'(i) && !bank_open[i]
                |=> !rdy_rw[i]); // R3
        end
    end

    if (RRD_C > 1) begin : g_rrd
        AST_RRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_vld && cmd_op == OP_ACT && !bank_open[cmd_bank]
            |=> rdy_act == '0); // R7
    end

    AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_ref |-> bank_open == '0); // R8

    AST_VIOL_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        viol_vld |-> viol_code != V_NONE); // R10

endmodule

bind sdram_bank_tracker sbt_checks #(
    .NB(NB), .RCD_C(RCD_C), .RRD_C(RRD_C)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .rdy_act(rdy_act), .rdy_rw(rdy_rw),
    .rdy_ref(rdy_ref), .bank_open(bank_open), .force_pre(force_pre),
    .viol_vld(viol_vld), .viol_code(viol_code)
);

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;
    // bench clocks at 10 ns: RCD 2, RAS_MIN 5, RAS_MAX 30, RP 2, RRD 2, WR 2, RC 7
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [3:0] rdy_act, rdy_rw, rdy_pre, bank_open, force_pre;
    logic       rdy_ref, viol_vld;
    logic [2:0] viol_code;
    logic [1:0] viol_bank;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sdram_bank_tracker #(
        .CLK_PS(10000), .T_WR_PS(15000), .T_RAS_MAX_PS(300000), .WARN_CLK(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .rdy_act(rdy_act), .rdy_rw(rdy_rw),
        .rdy_pre(rdy_pre), .rdy_ref(rdy_ref), .bank_open(bank_open),
        .force_pre(force_pre), .viol_vld(viol_vld), .viol_code(viol_code),
        .viol_bank(viol_bank)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input int b);
        cmd_op = op; cmd_bank = b[1:0]; cmd_vld = 1'b1;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_viol(input string tag, input int code, input int b);
        chk({tag, " vld"}, int'(viol_vld), (code != 0) ? 1 : 0);
        if (code != 0) begin
            chk({tag, " code"}, int'(viol_code), code);
            chk({tag, " bank"}, int'(viol_bank), b);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bank_open", int'(bank_open), 0);
        chk("R1 rdy_act", int'(rdy_act), 15);
        chk("R1 rdy_rw", int'(rdy_rw), 0);
        chk("R1 rdy_pre", int'(rdy_pre), 15);
        chk("R1 rdy_ref", int'(rdy_ref), 1);
        chk("R1 force_pre", int'(force_pre), 0);
        chk_viol("R1 viol", 0, 0);
    endtask

    task automatic t_rcd();
        do_reset();
        issue(3'd0, 0);
        chk_viol("R2 act", 0, 0);
        chk("R2 open", int'(bank_open[0]), 1);
        chk("R3 rdy_rw early", int'(rdy_rw[0]), 0);
        chk("R7 rdy_act other", int'(rdy_act[1]), 0);
        issue(3'd1, 0);
        chk_viol("R3 early read", 3, 0);
        chk("R3 rdy_rw at limit", int'(rdy_rw[0]), 1);
        issue(3'd1, 0);
        chk_viol("R4 read", 0, 0);
        issue(3'd2, 0);
        chk_viol("R4 write next clock", 0, 0);
        issue(3'd1, 0);
        chk_viol("R4 read next clock", 0, 0);
    endtask

    task automatic t_ras_rp();
        do_reset();
        issue(3'd0, 2);
        idle(3);
        chk("R5 rdy_pre age4", int'(rdy_pre[2]), 0);
        issue(3'd3, 2);
        chk_viol("R5 early pre", 4, 2);
        chk("R5 closed after early pre", int'(bank_open[2]), 0);
        chk("R6 rdy_act during rp", int'(rdy_act[2]), 0);
        issue(3'd0, 2);
        chk_viol("R6 early act", 5, 2);
        chk("R6 opens anyway", int'(bank_open[2]), 1);
        do_reset();
        issue(3'd0, 2);
        idle(4);
        chk("R13 rdy_pre age5", int'(rdy_pre[2]), 1);
        issue(3'd3, 2);
        chk_viol("R5 pre at limit", 0, 0);
        idle(1);
        chk("R6 rdy_act after rp", int'(rdy_act[2]), 1);
    endtask

    task automatic t_wr();
        do_reset();
        issue(3'd0, 3);
        idle(4);
        issue(3'd2, 3);
        chk("R5 rdy_pre after write", int'(rdy_pre[3]), 0);
        idle(1);
        chk("R5 rdy_pre write recovered", int'(rdy_pre[3]), 1);
        issue(3'd3, 3);
        chk_viol("R5 pre after wr", 0, 0);
        chk("R6 rdy_act right after pre", int'(rdy_act[3]), 0);
        idle(1);
        issue(3'd0, 3);
        chk_viol("R6 act after rp", 0, 0);
    endtask

    task automatic t_rrd();
        do_reset();
        issue(3'd0, 0);
        issue(3'd0, 1);
        chk_viol("R7 act too close", 5, 1);
        do_reset();
        issue(3'd0, 0);
        idle(1);
        chk("R7 rdy_act spaced", int'(rdy_act[1]), 1);
        issue(3'd0, 1);
        chk_viol("R7 act spaced", 0, 0);
    endtask

    task automatic t_state();
        do_reset();
        issue(3'd1, 1);
        chk_viol("R9 read closed", 1, 1);
        chk("R9 stays closed", int'(bank_open[1]), 0);
        issue(3'd2, 2);
        chk_viol("R9 write closed", 1, 2);
        issue(3'd0, 1);
        idle(2);
        issue(3'd0, 1);
        chk_viol("R9 act open", 2, 1);
        chk("R9 still open", int'(bank_open[1]), 1);
        chk("R9 row age kept", int'(rdy_pre[1]), 0);
        idle(1);
        chk_viol("R10 single pulse", 0, 0);
        issue(3'd6, 1);
        chk_viol("R2 unused op", 0, 0);
        chk("R2 unused op keeps open", int'(bank_open[1]), 1);
    endtask

    task automatic t_ref();
        do_reset();
        issue(3'd5, 0);
        chk_viol("R8 ref ok", 0, 0);
        chk("R8 rdy_ref busy", int'(rdy_ref), 0);
        issue(3'd0, 0);
        chk_viol("R8 act in rc", 5, 0);
        do_reset();
        issue(3'd5, 0);
        idle(5);
        chk("R8 rdy_act rc-1", int'(rdy_act[0]), 0);
        idle(1);
        chk("R8 rdy_act rc", int'(rdy_act[0]), 1);
        chk("R8 rdy_ref rc", int'(rdy_ref), 1);
        issue(3'd0, 0);
        chk("R8 rdy_ref open", int'(rdy_ref), 0);
        issue(3'd5, 0);
        chk_viol("R8 ref open", 6, 0);
    endtask

    task automatic t_prea();
        do_reset();
        issue(3'd0, 0);
        idle(1);
        issue(3'd0, 1);
        idle(2);
        issue(3'd4, 0);
        chk_viol("R11 prea early", 4, 1);
        chk("R11 all closed", int'(bank_open), 0);
        do_reset();
        issue(3'd0, 0);
        idle(1);
        issue(3'd0, 1);
        idle(4);
        issue(3'd4, 0);
        chk_viol("R11 prea ok", 0, 0);
        chk("R11 all closed ok", int'(bank_open), 0);
    endtask

    task automatic t_rasmax();
        do_reset();
        issue(3'd0, 0);
        idle(24);
        chk("R12 force before", int'(force_pre[0]), 0);
        idle(1);
        chk("R12 force at warn", int'(force_pre[0]), 1);
        idle(4);
        chk_viol("R12 no viol at limit", 0, 0);
        idle(1);
        chk_viol("R12 row too long", 7, 0);
        idle(1);
        chk_viol("R12 single pulse", 0, 0);
        do_reset();
        issue(3'd0, 0);
        idle(29);
        issue(3'd3, 0);
        chk_viol("R12 pre at max", 0, 0);
        chk("R12 force cleared", int'(force_pre[0]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rcd();
        t_ras_rp();
        t_wr();
        t_rrd();
        t_state();
        t_ref();
        t_prea();
        t_rasmax();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule